// File: doc/BRIEF.md
# Preferred-Path Progress Check and Crosspoint Enqueue Select

This block sits on one input of a mesh router that lets some flits travel along pre-enabled preferred paths before any routing decision has been made about them. Each cycle it looks at one incoming flit: its destination coordinates, the router's own coordinates, the side of the router it came in on, and whether it came by eager forwarding. From these it decides two things. First, it decides whether an eagerly forwarded flit is still useful or is dead. Second, for any flit that is still useful, it picks which crosspoint FIFO should receive it.

The progress test works on the last hop. A hop changes only one axis. The flit is live when that hop did not take it further from its destination on that axis. A flit that came from a neighbour by the normal path, or that was injected locally, is always live. Live flits are steered by dimension-ordered routing: X is resolved first, then Y. A flit already at its destination is sent to the local port.

A dead flag is raised for a flit that failed the test. Such a flit gets no FIFO select, so it is dropped here and never buffered again. Because a live preferred-path flit may be off the XY route, the same flit can arrive at its destination more than once. That is tolerated downstream.

All three outputs are registered, one clock after the inputs are sampled. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `eager_enq_check`

## Requirements
- R1: While reset is asserted, and from the moment it is asserted, enq_sel, flit_dead and deliver_local are all 0.
- R2: When in_valid is 0, all three outputs are 0 on the next cycle, whatever the other inputs are.
- R3: A live flit with dst_x greater than my_x selects the east FIFO (enq_sel bit 1). A live flit with dst_x less than my_x selects the west FIFO (bit 2). In both cases Y is not considered. The output appears one clock after sampling.
- R4: A live flit with dst_x equal to my_x is routed on Y. dst_y greater than my_y selects north (bit 3); dst_y less than my_y selects south (bit 4).
- R5: A flit whose destination equals the router's own coordinates selects the local FIFO (bit 0) and raises deliver_local. It is never flagged dead, even when eagerly forwarded.
- R6: A flit with in_eager low is always live. So is a flit whose arrival port is local (code 0) or an unused code (5 to 7).
- R7: Port codes are 1 for east and 2 for west; a port names the neighbour the flit came from. An eager flit on the west port is live only if dst_x >= my_x. An eager flit on the east port is live only if dst_x <= my_x. Otherwise it is dead.
- R8: Port codes are 3 for north and 4 for south; north is the side with larger Y. An eager flit on the south port is live only if dst_y >= my_y. An eager flit on the north port is live only if dst_y <= my_y. Otherwise it is dead.
- R9: A dead flit raises flit_dead, with enq_sel all zero and deliver_local low.
- R10: enq_sel never has more than one bit set. It has exactly one bit set for every valid, live flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A flit is present this cycle |
| in_eager | input | 1 | Flit came over a pre-enabled preferred path |
| in_port | input | 3 | Arrival side: 0 local, 1 east, 2 west, 3 north, 4 south |
| in_dst_x | input | COORD_W | Destination X coordinate from the header |
| in_dst_y | input | COORD_W | Destination Y coordinate from the header |
| my_x | input | COORD_W | This router's X coordinate |
| my_y | input | COORD_W | This router's Y coordinate |
| enq_sel | output | 5 | One-hot FIFO select: bit 0 local, 1 east, 2 west, 3 north, 4 south |
| flit_dead | output | 1 | The sampled flit was eagerly forwarded the wrong way |
| deliver_local | output | 1 | The sampled flit is for this router |

## Verification
The progress verdict and the XY choice are computed from the same flit in the same cycle. The verdict must win: an eager flit whose XY choice points straight back toward its arrival side must still come out with no select and the dead flag set. The bench provokes this with eager arrivals on each of the four sides, with destinations both on and off the hop's axis. It then compares the registered select, dead flag and local flag against values worked out from the rules.

A second overlap is local delivery. It is tried with eager arrivals whose destination equals the router, which sit on the boundary of the progress test. These must give local delivery and never the dead flag.

// File: rtl/eager_enq_pkg.sv
package eager_enq_pkg;
  localparam int PORT_W  = 3;
  localparam int NUM_OUT = 5;

  localparam logic [PORT_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [PORT_W-1:0] PORT_EAST  = 3'd1;
  localparam logic [PORT_W-1:0] PORT_WEST  = 3'd2;
  localparam logic [PORT_W-1:0] PORT_NORTH = 3'd3;
  localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd4;

  localparam int OUT_LOCAL = 0;
  localparam int OUT_EAST  = 1;
  localparam int OUT_WEST  = 2;
  localparam int OUT_NORTH = 3;
  localparam int OUT_SOUTH = 4;
endpackage

// File: rtl/eager_rst_sync.sv
module eager_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/eager_progress.sv
module eager_progress
  import eager_enq_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic               eager,
  input  logic [PORT_W-1:0]  arr_port,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] here_x,
  input  logic [COORD_W-1:0] here_y,
  output logic               live
);
  // The hop came from the neighbour on arr_port; only that axis moved.
  logic hop_ok;

  always_comb begin
    case (arr_port)
      PORT_WEST:  hop_ok = (dst_x >= here_x);
      PORT_EAST:  hop_ok = (dst_x <= here_x);
      PORT_SOUTH: hop_ok = (dst_y >= here_y);
      PORT_NORTH: hop_ok = (dst_y <= here_y);
      default:    hop_ok = 1'b1;
    endcase
  end

  assign live = !eager || hop_ok;
endmodule

// File: rtl/eager_xy_select.sv
module eager_xy_select
  import eager_enq_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] here_x,
  input  logic [COORD_W-1:0] here_y,
  output logic [NUM_OUT-1:0] sel,
  output logic               at_home
);
  localparam int IDX_W = $clog2(NUM_OUT);

  logic [IDX_W-1:0] dir_idx;

  always_comb begin
    if (dst_x > here_x)      dir_idx = IDX_W'(OUT_EAST);
    else if (dst_x < here_x) dir_idx = IDX_W'(OUT_WEST);
    else if (dst_y > here_y) dir_idx = IDX_W'(OUT_NORTH);
    else if (dst_y < here_y) dir_idx = IDX_W'(OUT_SOUTH);
    else                     dir_idx = IDX_W'(OUT_LOCAL);
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_dec
    assign sel[g] = (dir_idx == IDX_W'(g));
  end

  assign at_home = (dst_x == here_x) && (dst_y == here_y);
endmodule

// File: rtl/eager_enq_check.sv
module eager_enq_check
  import eager_enq_pkg::*;
#(
  parameter int COORD_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_eager,
  input  logic [2:0]         in_port,
  input  logic [COORD_W-1:0] in_dst_x,
  input  logic [COORD_W-1:0] in_dst_y,
  input  logic [COORD_W-1:0] my_x,
  input  logic [COORD_W-1:0] my_y,
  output logic [4:0]         enq_sel,
  output logic               flit_dead,
  output logic               deliver_local
);
  logic               rst_sync_n;
  logic               live;
  logic [NUM_OUT-1:0] route_sel;
  logic               at_home;

  logic [NUM_OUT-1:0] sel_d,   sel_q;
  logic               dead_d,  dead_q;
  logic               local_d, local_q;
  logic               cke;

  eager_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  eager_progress #(.COORD_W(COORD_W)) u_prog (
    .eager    (in_eager),
    .arr_port (in_port),
    .dst_x    (in_dst_x),
    .dst_y    (in_dst_y),
    .here_x   (my_x),
    .here_y   (my_y),
    .live     (live)
  );

  eager_xy_select #(.COORD_W(COORD_W)) u_xy (
    .dst_x   (in_dst_x),
    .dst_y   (in_dst_y),
    .here_x  (my_x),
    .here_y  (my_y),
    .sel     (route_sel),
    .at_home (at_home)
  );

  // Next state: a dead verdict overrides the route choice.
  always_comb begin
    sel_d   = '0;
    dead_d  = 1'b0;
    local_d = 1'b0;
    if (in_valid) begin
      if (live) begin
        sel_d   = route_sel;
        local_d = at_home;
      end else begin
        dead_d  = 1'b1;
      end
    end
  end

  // Load on a new flit, or once more to clear a held result.
  assign cke = in_valid || (|sel_q) || dead_q || local_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q   <= '0;
      dead_q  <= 1'b0;
      local_q <= 1'b0;
    end else if (cke) begin
      sel_q   <= sel_d;
      dead_q  <= dead_d;
      local_q <= local_d;
    end
  end

  assign enq_sel       = sel_q;
  assign flit_dead     = dead_q;
  assign deliver_local = local_q;
endmodule

// File: rtl/eager_enq_chk.sv
module eager_enq_chk #(
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_eager,
  input  logic [2:0]         in_port,
  input  logic [COORD_W-1:0] in_dst_x,
  input  logic [COORD_W-1:0] in_dst_y,
  input  logic [COORD_W-1:0] my_x,
  input  logic [COORD_W-1:0] my_y,
  input  logic [4:0]         enq_sel,
  input  logic               flit_dead,
  input  logic               deliver_local
);
  // R2
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (enq_sel == 5'd0 && !flit_dead && !deliver_local));

  // R10
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(enq_sel));

  // R10
  p_live_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_eager) |=> ($countones(enq_sel) == 1));

  // R9
  p_dead_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flit_dead |-> (enq_sel == 5'd0 && !deliver_local));

  // R5
  p_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dst_x == my_x && in_dst_y == my_y)
      |=> (deliver_local && enq_sel == 5'b00001 && !flit_dead));

  // R6
  p_direct_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_eager) |=> !flit_dead);

  // R7
  p_west_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eager && in_port == 3'd2 && in_dst_x < my_x) |=> flit_dead);

  // R8
  p_north_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eager && in_port == 3'd3 && in_dst_y > my_y) |=> flit_dead);
endmodule

bind eager_enq_check eager_enq_chk #(.COORD_W(COORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .in_valid      (in_valid),
  .in_eager      (in_eager),
  .in_port       (in_port),
  .in_dst_x      (in_dst_x),
  .in_dst_y      (in_dst_y),
  .my_x          (my_x),
  .my_y          (my_y),
  .enq_sel       (enq_sel),
  .flit_dead     (flit_dead),
  .deliver_local (deliver_local)
);

// File: tb/sim_eager_enq_check.sv
module sim_eager_enq_check;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  // {tag[31:28], valid, eager, port[2:0], my_x, my_y, dst_x, dst_y, sel[4:0], dead, local}
  localparam logic [31:0] VEC [NV] = '{
    {4'd3, 1'b1,1'b0,3'd0, 4'd5,4'd5, 4'd9,4'd5,  5'b00010,1'b0,1'b0},
    {4'd3, 1'b1,1'b0,3'd0, 4'd5,4'd5, 4'd2,4'd5,  5'b00100,1'b0,1'b0},
    {4'd4, 1'b1,1'b0,3'd0, 4'd5,4'd5, 4'd5,4'd9,  5'b01000,1'b0,1'b0},
    {4'd4, 1'b1,1'b0,3'd0, 4'd5,4'd5, 4'd5,4'd1,  5'b10000,1'b0,1'b0},
    {4'd3, 1'b1,1'b0,3'd0, 4'd5,4'd5, 4'd9,4'd1,  5'b00010,1'b0,1'b0},
    {4'd5, 1'b1,1'b0,3'd0, 4'd5,4'd5, 4'd5,4'd5,  5'b00001,1'b0,1'b1},
    {4'd2, 1'b0,1'b1,3'd2, 4'd5,4'd5, 4'd1,4'd5,  5'b00000,1'b0,1'b0},
    {4'd7, 1'b1,1'b1,3'd2, 4'd5,4'd5, 4'd9,4'd2,  5'b00010,1'b0,1'b0},
    {4'd9, 1'b1,1'b1,3'd2, 4'd5,4'd5, 4'd1,4'd5,  5'b00000,1'b1,1'b0},
    {4'd7, 1'b1,1'b1,3'd1, 4'd5,4'd5, 4'd1,4'd9,  5'b00100,1'b0,1'b0},
    {4'd7, 1'b1,1'b1,3'd1, 4'd5,4'd5, 4'd8,4'd5,  5'b00000,1'b1,1'b0},
    {4'd7, 1'b1,1'b1,3'd1, 4'd5,4'd5, 4'd5,4'd9,  5'b01000,1'b0,1'b0},
    {4'd8, 1'b1,1'b1,3'd4, 4'd5,4'd5, 4'd5,4'd9,  5'b01000,1'b0,1'b0},
    {4'd9, 1'b1,1'b1,3'd4, 4'd5,4'd5, 4'd5,4'd2,  5'b00000,1'b1,1'b0},
    {4'd8, 1'b1,1'b1,3'd3, 4'd5,4'd5, 4'd3,4'd2,  5'b00100,1'b0,1'b0},
    {4'd8, 1'b1,1'b1,3'd3, 4'd5,4'd5, 4'd7,4'd8,  5'b00000,1'b1,1'b0},
    {4'd6, 1'b1,1'b1,3'd0, 4'd5,4'd5, 4'd1,4'd1,  5'b00100,1'b0,1'b0},
    {4'd6, 1'b1,1'b1,3'd6, 4'd5,4'd5, 4'd1,4'd1,  5'b00100,1'b0,1'b0},
    {4'd6, 1'b1,1'b0,3'd1, 4'd5,4'd5, 4'd9,4'd5,  5'b00010,1'b0,1'b0},
    {4'd5, 1'b1,1'b1,3'd2, 4'd5,4'd5, 4'd5,4'd5,  5'b00001,1'b0,1'b1},
    {4'd3, 1'b1,1'b0,3'd0, 4'd0,4'd0, 4'd15,4'd15,5'b00010,1'b0,1'b0},
    {4'd8, 1'b1,1'b1,3'd3, 4'd15,4'd15,4'd0,4'd0, 5'b00100,1'b0,1'b0},
    {4'd8, 1'b1,1'b1,3'd4, 4'd15,4'd15,4'd15,4'd0,5'b00000,1'b1,1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_eager;
  logic [2:0] in_port;
  logic [3:0] in_dst_x, in_dst_y, my_x, my_y;
  logic [4:0] enq_sel;
  logic       flit_dead, deliver_local;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eager_enq_check u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eager(in_eager),
    .in_port(in_port), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
    .my_x(my_x), .my_y(my_y), .enq_sel(enq_sel), .flit_dead(flit_dead),
    .deliver_local(deliver_local)
  );

  function automatic string rname(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_out(input string req, input logic [4:0] es,
                           input logic ed, input logic el);
    checks++;
    if (enq_sel !== es || flit_dead !== ed || deliver_local !== el) begin
      errors++;
      $display("FAIL %s: sel=%b dead=%b local=%b expected sel=%b dead=%b local=%b",
               req, enq_sel, flit_dead, deliver_local, es, ed, el);
    end
  endtask

  task automatic drive(input logic v, input logic e, input logic [2:0] p,
                       input logic [3:0] mx, input logic [3:0] my,
                       input logic [3:0] dx, input logic [3:0] dy);
    in_valid = v; in_eager = e; in_port = p;
    my_x = mx; my_y = my; in_dst_x = dx; in_dst_y = dy;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 3'd0, 4'd5, 4'd5, 4'd9, 4'd5);
    repeat (3) @(negedge clk);
    check_out("R1", 5'b0, 1'b0, 1'b0);          // R1: held in reset despite valid input
    drive(1'b0, 1'b0, 3'd0, 4'd5, 4'd5, 4'd5, 4'd5);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1", 5'b0, 1'b0, 1'b0);          // R1: idle after release

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      drive(v[27], v[26], v[25:23], v[22:19], v[18:15], v[14:11], v[10:7]);
      @(negedge clk);
      check_out(rname(v[31:28]), v[6:2], v[1], v[0]);
      if (v[27] && !v[1]) begin                 // R10: exactly one select for a live flit
        checks++;
        if ($countones(enq_sel) != 1) begin
          errors++;
          $display("FAIL R10: sel=%b ones=%0d expected ones=1", enq_sel, $countones(enq_sel));
        end
      end
    end

    // R2: a held route clears once valid drops, even with a dead-looking flit on the inputs
    drive(1'b1, 1'b0, 3'd0, 4'd5, 4'd5, 4'd5, 4'd9);
    @(negedge clk);
    check_out("R4", 5'b01000, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 3'd1, 4'd5, 4'd5, 4'd9, 4'd5);
    @(negedge clk);
    check_out("R2", 5'b0, 1'b0, 1'b0);

    // R9 then R5 back to back: dead verdict does not linger into local delivery
    drive(1'b1, 1'b1, 3'd4, 4'd3, 4'd7, 4'd3, 4'd6);
    @(negedge clk);
    check_out("R9", 5'b0, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 3'd4, 4'd3, 4'd7, 4'd3, 4'd7);
    @(negedge clk);
    check_out("R5", 5'b00001, 1'b0, 1'b1);

    // R1: asynchronous assertion clears outputs without a clock edge
    drive(1'b1, 1'b0, 3'd0, 4'd5, 4'd5, 4'd9, 4'd5);
    @(negedge clk);
    check_out("R3", 5'b00010, 1'b0, 1'b0);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check_out("R1", 5'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 3'd0, 4'd5, 4'd5, 4'd5, 4'd5);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule